// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Coherence Controller

This block keeps one processor's private, direct-mapped, write-back cache coherent with its peers on a shared snooping bus. Every line carries one of three states: Invalid (holds nothing usable), Shared (clean copy that may only be read) and Exclusive (the only copy, writable and dirty). A line moves between these states in response to two sources. One is the local processor's loads and stores. The other is the miss commands that other bus agents broadcast.

The processor side is a valid/ready request channel. The processor raises `cpu_valid` with the operation, address and store data, and holds all of them stable until `cpu_ready` is seen high at a clock edge. A low `cpu_ready` is back-pressure (a stall). Loads return data on `cpu_rdata` in the cycle `cpu_ready` is high. A hit completes in the cycle it is presented. A miss first wins the bus, then installs the line, and then completes as a hit.

The bus side is a plain request/grant pair. A bus transaction is a single granted cycle. In that cycle the granted controller drives a command and an address. The fill word on `bus_rdata` comes back in the same cycle, either from memory or from a peer that holds the line dirty. The snoop side watches the other agents' commands. When the snooped miss targets a dirty line here, the controller raises `snp_abort` and drives the dirty word on `snp_data` in that same cycle, so that memory drops its own stale reply and records the supplied word.

Top module: `snoop_msi_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req` and `cpu_ready` are low, and the first access to any address misses.
- R2: These accesses assert `cpu_ready` in the cycle they are presented and raise no bus request: a load to a Shared or Exclusive line whose tag matches, and a store to an Exclusive line whose tag matches.
- R3: A load that misses, with a victim that is not dirty, issues exactly one read-miss transaction (`bus_cmd` = 1) for the load address. The line becomes Shared and holds the word returned on `bus_rdata`.
- R4: A store to an Invalid line, or to a Shared line with either tag, issues one write-miss transaction (`bus_cmd` = 2). The line becomes Exclusive and is then written with the store data.
- R5: A miss whose victim line is Exclusive with another tag first issues a write-back (`bus_cmd` = 3) carrying the victim's address and word. Only after that does it issue the read-miss or write-miss.
- R6: A snooped read-miss (`snp_cmd` = 1) that matches an Exclusive line raises `snp_abort`, supplies the line's word on `snp_data` in the same cycle, and leaves the line Shared.
- R7: A snooped write-miss (`snp_cmd` = 2) that matches a line makes it Invalid. If the line was Exclusive, the controller also raises `snp_abort` and supplies the word. A snooped command that matches no line has no effect.
- R8: `bus_cmd` is non-zero only in cycles where `bus_gnt` is high. The request stays high until it is granted, and no line changes state for the controller's own miss before the grant.
- R9: A cycle with `snp_valid` high takes the lookup from the processor, so `cpu_ready` stays low in that cycle even for a hit.
- R10: While a miss waits for grant, a snooped command that acts on the pending line is applied first, and the request is restarted and decided again. For example, a victim that a snoop has already written back is not written back a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request completes at this clock edge |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant for this cycle |
| bus_cmd | output | 2 | 0 none, 1 read-miss, 2 write-miss, 3 write-back |
| bus_addr | output | ADDR_W | Address of the issued command |
| bus_wdata | output | DATA_W | Word carried by a write-back |
| bus_rdata | input | DATA_W | Fill word for an issued miss |
| snp_valid | input | 1 | Another agent's command is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_abort | output | 1 | This cache supplies the word; memory reply is dropped |
| snp_data | output | DATA_W | Supplied dirty word |

## Verification
The assertions check properties that must hold on every cycle. Commands appear only under grant. A completed hit never coincides with a bus request. A snooped cycle always stalls the processor. An abort appears only for a snooped miss. A request stays raised until it is granted, and a write-back is always followed by the miss it clears the way for. Other behaviour only the bench's scenarios can show, because it needs two controllers and a memory that disagree with each other: the state each line reaches, which copy of a word a load returns, the order of write-back and miss, and the absence of a second write-back after a snoop restarts a pending miss.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WBACK  = 2'd3
  } bus_cmd_t;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_WB   = 2'd1,
    FS_MISS = 2'd2
  } fsm_st_t;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output logic [1:0]        a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_dat,
  input  logic [IDX_W-1:0]  b_idx,
  output logic [1:0]        b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_dat,
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic [1:0]        sw_st,
  input  logic              fw_en,
  input  logic [IDX_W-1:0]  fw_idx,
  input  logic [1:0]        fw_st,
  input  logic              fw_tag_en,
  input  logic [TAG_W-1:0]  fw_tag,
  input  logic              fw_dat_en,
  input  logic [DATA_W-1:0] fw_dat
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0][1:0]        st_v;
  logic [LINES-1:0][TAG_W-1:0]  tag_v;
  logic [LINES-1:0][DATA_W-1:0] dat_v;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic              sel_s, sel_f;
    logic [1:0]        st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] dat_q;

    assign sel_s = sw_en && (sw_idx == IDX_W'(i));
    assign sel_f = fw_en && (fw_idx == IDX_W'(i));

    // snoop updates win over the local port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q <= LS_INV;
      else if (sel_s) st_q <= sw_st;
      else if (sel_f) st_q <= fw_st;
    end

    always_ff @(posedge clk) begin
      if (sel_f && !sel_s) begin
        if (fw_tag_en) tag_q <= fw_tag;
        if (fw_dat_en) dat_q <= fw_dat;
      end
    end

    assign st_v[i]  = st_q;
    assign tag_v[i] = tag_q;
    assign dat_v[i] = dat_q;
  end

  assign a_st  = st_v[a_idx];
  assign a_tag = tag_v[a_idx];
  assign a_dat = dat_v[a_idx];
  assign b_st  = st_v[b_idx];
  assign b_tag = tag_v[b_idx];
  assign b_dat = dat_v[b_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic [1:0]        line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_dat,
  output logic              act,
  output logic [1:0]        new_st,
  output logic              abort,
  output logic [DATA_W-1:0] sup_dat
);
  logic match, is_rd, is_wr, dirty;

  assign match   = snp_valid && (line_st != LS_INV) && (line_tag == snp_tag);
  assign is_rd   = (snp_cmd == BC_RDMISS);
  assign is_wr   = (snp_cmd == BC_WRMISS);
  assign dirty   = (line_st == LS_EXC);
  assign act     = match && (is_wr || (is_rd && dirty));
  assign new_st  = is_wr ? LS_INV : LS_SHR;
  assign abort   = act && dirty;
  assign sup_dat = abort ? line_dat : '0;
endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_valid,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic                    cpu_ready,
  output logic [DATA_W-1:0]       cpu_rdata,
  input  logic                    snp_valid,
  input  logic                    snp_act,
  input  logic [IDX_W-1:0]        snp_idx,
  output logic [IDX_W-1:0]        look_idx,
  input  logic [1:0]              look_st,
  input  logic [ADDR_W-IDX_W-1:0] look_tag,
  input  logic [DATA_W-1:0]       look_dat,
  output logic                    bus_req,
  input  logic                    bus_gnt,
  output logic [1:0]              bus_cmd,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  input  logic [DATA_W-1:0]       bus_rdata,
  output logic                    fw_en,
  output logic [1:0]              fw_st,
  output logic                    fw_tag_en,
  output logic [ADDR_W-IDX_W-1:0] fw_tag,
  output logic                    fw_dat_en,
  output logic [DATA_W-1:0]       fw_dat
);
  fsm_st_t           fs, nxt;
  logic [ADDR_W-1:0] pend_addr;
  logic              pend_we, ld, tag_eq, hit, restart;
  logic [IDX_W-1:0]  pend_idx;

  assign pend_idx  = pend_addr[IDX_W-1:0];
  assign look_idx  = (fs == FS_IDLE) ? cpu_addr[IDX_W-1:0] : pend_idx;
  assign tag_eq    = (look_tag == cpu_addr[ADDR_W-1:IDX_W]);
  assign hit       = (look_st != LS_INV) && tag_eq && (!cpu_we || look_st == LS_EXC);
  assign restart   = snp_act && (snp_idx == pend_idx);
  assign cpu_rdata = look_dat;

  always_comb begin
    nxt = fs; ld = 1'b0; cpu_ready = 1'b0;
    bus_req = 1'b0; bus_cmd = BC_NONE; bus_addr = '0; bus_wdata = '0;
    fw_en = 1'b0; fw_st = LS_INV; fw_tag_en = 1'b0; fw_tag = '0;
    fw_dat_en = 1'b0; fw_dat = '0;
    unique case (fs)
      FS_IDLE: begin
        if (cpu_valid && !snp_valid) begin
          if (hit) begin
            cpu_ready = 1'b1;
            if (cpu_we) begin
              fw_en = 1'b1; fw_st = LS_EXC; fw_dat_en = 1'b1; fw_dat = cpu_wdata;
            end
          end else begin
            ld  = 1'b1;
            nxt = (look_st == LS_EXC && !tag_eq) ? FS_WB : FS_MISS;
          end
        end
      end
      FS_WB: begin
        bus_req = 1'b1;
        if (bus_gnt) begin
          bus_cmd   = BC_WBACK;
          bus_addr  = {look_tag, pend_idx};
          bus_wdata = look_dat;
          fw_en = 1'b1; fw_st = LS_INV;
          nxt = FS_MISS;
        end else if (restart) begin
          nxt = FS_IDLE;
        end
      end
      FS_MISS: begin
        bus_req = 1'b1;
        if (bus_gnt) begin
          bus_cmd  = pend_we ? BC_WRMISS : BC_RDMISS;
          bus_addr = pend_addr;
          fw_en = 1'b1; fw_st = pend_we ? LS_EXC : LS_SHR;
          fw_tag_en = 1'b1; fw_tag = pend_addr[ADDR_W-1:IDX_W];
          fw_dat_en = 1'b1; fw_dat = bus_rdata;
          nxt = FS_IDLE;
        end else if (restart) begin
          nxt = FS_IDLE;
        end
      end
      default: nxt = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs <= FS_IDLE; pend_addr <= '0; pend_we <= 1'b0;
    end else begin
      fs <= nxt;
      if (ld) begin
        pend_addr <= cpu_addr; pend_we <= cpu_we;
      end
    end
  end
endmodule

// File: rtl/snoop_msi_ctrl.sv
module snoop_msi_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_abort,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  look_idx, snp_idx;
  logic [1:0]        look_st, sl_st, snp_new_st, fw_st;
  logic [TAG_W-1:0]  look_tag, sl_tag, fw_tag;
  logic [DATA_W-1:0] look_dat, sl_dat, fw_dat;
  logic              snp_act, fw_en, fw_tag_en, fw_dat_en;

  assign snp_idx = snp_addr[IDX_W-1:0];

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(look_idx), .a_st(look_st), .a_tag(look_tag), .a_dat(look_dat),
    .b_idx(snp_idx), .b_st(sl_st), .b_tag(sl_tag), .b_dat(sl_dat),
    .sw_en(snp_act), .sw_idx(snp_idx), .sw_st(snp_new_st),
    .fw_en(fw_en), .fw_idx(look_idx), .fw_st(fw_st),
    .fw_tag_en(fw_tag_en), .fw_tag(fw_tag), .fw_dat_en(fw_dat_en), .fw_dat(fw_dat)
  );

  msi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snp (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
    .line_st(sl_st), .line_tag(sl_tag), .line_dat(sl_dat),
    .act(snp_act), .new_st(snp_new_st), .abort(snp_abort), .sup_dat(snp_data)
  );

  msi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .snp_valid(snp_valid), .snp_act(snp_act), .snp_idx(snp_idx),
    .look_idx(look_idx), .look_st(look_st), .look_tag(look_tag), .look_dat(look_dat),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fw_en(fw_en), .fw_st(fw_st), .fw_tag_en(fw_tag_en), .fw_tag(fw_tag),
    .fw_dat_en(fw_dat_en), .fw_dat(fw_dat)
  );
endmodule

// File: rtl/msi_chk.sv
module msi_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_ready,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic [1:0] bus_cmd,
  input logic       snp_valid,
  input logic [1:0] snp_cmd,
  input logic       snp_abort
);
  AST_CMD_ONLY_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'd0) |-> bus_gnt); // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snp_valid) |=> bus_req); // R8
  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !bus_req); // R2
  AST_SNOOP_STALLS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_ready); // R9
  AST_ABORT_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_abort |-> (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2))); // R6 R7
  AST_WB_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && bus_cmd == 2'd3) |=> bus_req); // R5
endmodule

bind snoop_msi_ctrl msi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .bus_req(bus_req),
  .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .snp_valid(snp_valid),
  .snp_cmd(snp_cmd), .snp_abort(snp_abort)
);

// File: tb/sim_snoop_msi_ctrl.sv
`timescale 1ns/1ps
module sim_snoop_msi_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cv[2], cw[2];
  logic [7:0]  ca[2];
  logic [15:0] cd[2];
  logic        cr[2];
  logic [15:0] crd[2];
  logic        breq[2], gnt[2], sv[2], sab[2];
  logic [1:0]  bcmd[2], sc[2];
  logic [7:0]  badr[2], sa[2];
  logic [15:0] bwd[2], sdat[2];

  logic        arb_en, prio, inj_v;
  logic [1:0]  inj_cmd, m_cmd;
  logic [7:0]  inj_adr, m_adr;
  logic [15:0] m_wd, sup, fill;
  logic        abort_any;
  logic [15:0] mem [256];

  int checks = 0, errors = 0;
  int nb[2];
  logic [1:0] hist0 [64];
  logic [1:0] hist1 [64];

  snoop_msi_ctrl u0 (.clk(clk), .rst_n(rst_n), .cpu_valid(cv[0]), .cpu_we(cw[0]),
    .cpu_addr(ca[0]), .cpu_wdata(cd[0]), .cpu_ready(cr[0]), .cpu_rdata(crd[0]),
    .bus_req(breq[0]), .bus_gnt(gnt[0]), .bus_cmd(bcmd[0]), .bus_addr(badr[0]),
    .bus_wdata(bwd[0]), .bus_rdata(fill), .snp_valid(sv[0]), .snp_cmd(sc[0]),
    .snp_addr(sa[0]), .snp_abort(sab[0]), .snp_data(sdat[0]));
  snoop_msi_ctrl u1 (.clk(clk), .rst_n(rst_n), .cpu_valid(cv[1]), .cpu_we(cw[1]),
    .cpu_addr(ca[1]), .cpu_wdata(cd[1]), .cpu_ready(cr[1]), .cpu_rdata(crd[1]),
    .bus_req(breq[1]), .bus_gnt(gnt[1]), .bus_cmd(bcmd[1]), .bus_addr(badr[1]),
    .bus_wdata(bwd[1]), .bus_rdata(fill), .snp_valid(sv[1]), .snp_cmd(sc[1]),
    .snp_addr(sa[1]), .snp_abort(sab[1]), .snp_data(sdat[1]));

  // bus model: arbiter, snoop routing, memory with abort handling
  assign gnt[0] = arb_en && breq[0] && (!breq[1] || !prio);
  assign gnt[1] = arb_en && breq[1] && !(breq[0] && !prio);
  assign m_cmd  = inj_v ? inj_cmd : (gnt[0] ? bcmd[0] : (gnt[1] ? bcmd[1] : 2'd0));
  assign m_adr  = inj_v ? inj_adr : (gnt[0] ? badr[0] : badr[1]);
  assign m_wd   = gnt[0] ? bwd[0] : bwd[1];
  assign sv[0]  = inj_v || gnt[1];
  assign sc[0]  = inj_v ? inj_cmd : bcmd[1];
  assign sa[0]  = inj_v ? inj_adr : badr[1];
  assign sv[1]  = inj_v || gnt[0];
  assign sc[1]  = inj_v ? inj_cmd : bcmd[0];
  assign sa[1]  = inj_v ? inj_adr : badr[0];
  assign abort_any = sab[0] || sab[1];
  assign sup    = sab[0] ? sdat[0] : sdat[1];
  assign fill   = abort_any ? sup : mem[m_adr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 16'hA500 ^ 16'(i);
      prio <= 1'b0;
      nb[0] <= 0; nb[1] <= 0;
    end else begin
      if (m_cmd == 2'd3) mem[m_adr] <= m_wd;
      else if (m_cmd != 2'd0 && abort_any) mem[m_adr] <= sup;
      if (gnt[0] || gnt[1]) prio <= gnt[0];
      if (gnt[0]) begin hist0[nb[0][5:0]] <= bcmd[0]; nb[0] <= nb[0] + 1; end
      if (gnt[1]) begin hist1[nb[1][5:0]] <= bcmd[1]; nb[1] <= nb[1] + 1; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  bit hung = 1'b0;

  task automatic cpu_op(input int c, input logic we, input logic [7:0] a, input logic [15:0] wd,
                        output logic [15:0] rd, output int stalls, output int nbus, output int b0);
    b0 = nb[c];
    @(negedge clk);
    cv[c] = 1'b1; cw[c] = we; ca[c] = a; cd[c] = wd; stalls = 0;
    #5;
    while (!cr[c] && !hung) begin
      stalls++;
      if (stalls > 2000) hung = 1'b1;
      @(negedge clk); #5;
    end
    rd = crd[c];
    @(negedge clk);
    cv[c] = 1'b0;
    nbus = nb[c] - b0;
  endtask

  typedef struct packed {
    logic        c;
    logic        we;
    logic [7:0]  a;
    logic [15:0] wd;
    logic [15:0] exp;
    logic [1:0]  nbus;
  } vec_t;

  localparam vec_t VECS [19] = '{
    '{1'b0, 1'b0, 8'h10, 16'h0000, 16'hA510, 2'd1},
    '{1'b1, 1'b0, 8'h10, 16'h0000, 16'hA510, 2'd1},
    '{1'b0, 1'b1, 8'h10, 16'h1111, 16'h0000, 2'd1},
    '{1'b1, 1'b0, 8'h10, 16'h0000, 16'h1111, 2'd1},
    '{1'b1, 1'b1, 8'h10, 16'h2222, 16'h0000, 2'd1},
    '{1'b0, 1'b0, 8'h10, 16'h0000, 16'h2222, 2'd1},
    '{1'b0, 1'b1, 8'h14, 16'h3333, 16'h0000, 2'd1},
    '{1'b0, 1'b0, 8'h18, 16'h0000, 16'hA518, 2'd2},
    '{1'b1, 1'b0, 8'h14, 16'h0000, 16'h3333, 2'd1},
    '{1'b0, 1'b0, 8'h10, 16'h0000, 16'h2222, 2'd1},
    '{1'b1, 1'b1, 8'h21, 16'h4444, 16'h0000, 2'd1},
    '{1'b1, 1'b1, 8'h21, 16'h5555, 16'h0000, 2'd0},
    '{1'b0, 1'b0, 8'h21, 16'h0000, 16'h5555, 2'd1},
    '{1'b0, 1'b1, 8'h31, 16'h6666, 16'h0000, 2'd1},
    '{1'b1, 1'b0, 8'h31, 16'h0000, 16'h6666, 2'd1},
    '{1'b1, 1'b0, 8'h31, 16'h0000, 16'h6666, 2'd0},
    '{1'b0, 1'b1, 8'h31, 16'h7A7A, 16'h0000, 2'd1},
    '{1'b1, 1'b1, 8'h31, 16'h8B8B, 16'h0000, 2'd1},
    '{1'b0, 1'b0, 8'h31, 16'h0000, 16'h8B8B, 2'd1}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] rd;
    int st, nbus, b0;
    for (int i = 0; i < 2; i++) begin cv[i] = 0; cw[i] = 0; ca[i] = 0; cd[i] = 0; end
    arb_en = 1'b1; inj_v = 1'b0; inj_cmd = 2'd0; inj_adr = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #5;
    // R1: reset state at the ports
    chk(cr[0] == 1'b0 && cr[1] == 1'b0, "R1 ready low after reset", {31'b0, cr[0] | cr[1]}, 32'h0);
    chk(breq[0] == 1'b0 && breq[1] == 1'b0, "R1 bus_req low after reset", {31'b0, breq[0] | breq[1]}, 32'h0);

    // vector table: R1 R2 R3 R4 R5 R6 R7 across two caches
    for (int v = 0; v < 19; v++) begin
      cpu_op(int'(VECS[v].c), VECS[v].we, VECS[v].a, VECS[v].wd, rd, st, nbus, b0);
      if (!VECS[v].we)
        chk(rd == VECS[v].exp, $sformatf("R3 R6 R7 load data vec %0d", v), {16'h0, rd}, {16'h0, VECS[v].exp});
      chk(nbus == int'(VECS[v].nbus), $sformatf("R4 R5 bus transaction count vec %0d", v), nbus, VECS[v].nbus);
      if (VECS[v].nbus == 2'd0)
        chk(st == 0, $sformatf("R2 hit completes without stall vec %0d", v), st, 0);
      if (VECS[v].nbus == 2'd2 && !VECS[v].c) begin
        chk(hist0[b0[5:0]] == 2'd3, "R5 write-back issued first", {30'b0, hist0[b0[5:0]]}, 32'd3);
        chk(hist0[6'(b0 + 1)] == 2'd1, "R5 read-miss follows write-back", {30'b0, hist0[6'(b0 + 1)]}, 32'd1);
      end
    end
    chk(mem[8'h14] == 16'h3333, "R5 victim word reached memory", {16'h0, mem[8'h14]}, 32'h3333);
    chk(mem[8'h31] == 16'h8B8B, "R6 supplied word absorbed by memory", {16'h0, mem[8'h31]}, 32'h8B8B);

    // R9: snoop lookup wins over a CPU hit in the same cycle
    @(negedge clk);
    cv[0] = 1'b1; cw[0] = 1'b0; ca[0] = 8'h31;
    inj_v = 1'b1; inj_cmd = 2'd1; inj_adr = 8'h77;
    #5;
    chk(cr[0] == 1'b0, "R9 cpu stalled during snoop", {31'b0, cr[0]}, 32'h0);
    @(negedge clk);
    inj_v = 1'b0;
    #5;
    chk(cr[0] == 1'b1 && crd[0] == 16'h8B8B, "R9 R7 hit after snoop, unmatched snoop ignored",
        {15'b0, cr[0], crd[0]}, {15'b0, 1'b1, 16'h8B8B});
    @(negedge clk);
    cv[0] = 1'b0;

    // R10: snoop hits the dirty victim while a miss waits for grant
    cpu_op(0, 1'b1, 8'h42, 16'h7777, rd, st, nbus, b0);
    arb_en = 1'b0;
    @(negedge clk);
    cv[0] = 1'b1; cw[0] = 1'b0; ca[0] = 8'h46;
    b0 = nb[0];
    repeat (3) @(negedge clk);
    #5;
    chk(breq[0] == 1'b1 && bcmd[0] == 2'd0 && nb[0] == b0, "R8 request waits, no command without grant",
        {30'b0, breq[0], |bcmd[0]}, 32'h2);
    @(negedge clk);
    inj_v = 1'b1; inj_cmd = 2'd1; inj_adr = 8'h42;
    #5;
    chk(sab[0] == 1'b1 && sdat[0] == 16'h7777, "R6 abort and supply on snooped read",
        {15'b0, sab[0], sdat[0]}, {15'b0, 1'b1, 16'h7777});
    @(negedge clk);
    inj_v = 1'b0;
    arb_en = 1'b1;
    #5;
    st = 0;
    while (!cr[0] && st < 2000) begin st++; @(negedge clk); #5; end
    chk(crd[0] == 16'hA546, "R3 R10 restarted load data", {16'h0, crd[0]}, 32'hA546);
    @(negedge clk);
    cv[0] = 1'b0;
    chk(nb[0] - b0 == 1, "R10 single transaction after restart", nb[0] - b0, 1);
    chk(hist0[b0[5:0]] == 2'd1, "R10 no second write-back, read-miss issued", {30'b0, hist0[b0[5:0]]}, 32'd1);
    cpu_op(1, 1'b0, 8'h42, 16'h0, rd, st, nbus, b0);
    chk(rd == 16'h7777, "R6 memory holds supplied word", {16'h0, rd}, 32'h7777);

    if (hung) begin
      checks++; errors++;
      $display("FAIL watchdog request never completed actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule